// File: doc/BRIEF.md
# Sync Polarity, Presence and Vertical Source Front End

This block takes two raw sync inputs. The first carries either a horizontal sync or a composite horizontal/vertical sync. The second carries a vertical sync only. Each input is brought into the reference clock domain through a short synchronizer chain. For each input, the block measures the pulse polarity period by period and flips the signal so that it leaves the block as a positive-going sync. It also keeps a presence flag that drops when the input has gone quiet for a programmable time.

The corrected composite signal drives the horizontal sync output directly. The same signal feeds an integrating extractor: a saturating up/down counter that rises past a threshold only during the long vertical-interval pulses, and never on ordinary line pulses. The vertical sync output comes from one of two sources, either the dedicated vertical input or the extractor. The choice follows a manual bit, or, in automatic mode, the presence of the vertical input. A five-bit status word reports the three presence flags and the two polarity decisions.

Top module: `sync_frontend`

## Requirements
- R1: `hSyncOut` is the corrected composite input, delayed by SYNC_STAGES+1 clock cycles (3 with the default), and active high.
- R2: At each rising edge of an input, polarity is judged from the low run that just ended and the high run before it. A low run strictly shorter than the high run means negative; a tie means positive. The decision for the composite input is reported in `status[4]` and the decision for the vertical input in `status[3]`. A value of 1 means negative.
- R3: A polarity decision changes only after POL_CONFIRM consecutive periods disagree with it. Shorter bursts of the opposite shape, such as serrated vertical-interval lines, leave the decision unchanged.
- R4: With `cfgAutoPol`=1, each input is inverted when its detected polarity is negative. With `cfgAutoPol`=0, the inputs are inverted according to `cfgCompInv` and `cfgVertInv`.
- R5: The extractor counts up (saturating at 2^INTEG_W-1) while the corrected composite signal is high and counts down (saturating at 0) while it is low. The extracted vertical is high while the count exceeds INTEG_THRESH. Horizontal pulses shorter than INTEG_THRESH cycles never produce an extracted vertical.
- R6: A presence flag sets on any edge of its signal and clears after PRES_TIMEOUT cycles with no edge. The flags are: `status[0]` for the vertical input, `status[1]` for the composite input, and `status[2]` for the extracted vertical.
- R7: With `cfgAutoSel`=1, `vSyncOut` follows the corrected vertical input when `status[0]` is 1, and follows the extracted vertical otherwise.
- R8: With `cfgAutoSel`=0, `vSyncOut` follows the extracted vertical when `cfgSelExtract`=1 and the corrected vertical input when `cfgSelExtract`=0.
- R9: After reset with both inputs low, `status` is 0 and both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| compSyncIn | input | 1 | Horizontal or composite sync, either polarity |
| vertSyncIn | input | 1 | Vertical-only sync, either polarity |
| cfgAutoPol | input | 1 | 1: invert from detected polarity; 0: use manual bits |
| cfgCompInv | input | 1 | Manual inversion of the composite input |
| cfgVertInv | input | 1 | Manual inversion of the vertical input |
| cfgAutoSel | input | 1 | 1: automatic vertical source selection |
| cfgSelExtract | input | 1 | Manual source: 1 extracted, 0 vertical input |
| hSyncOut | output | 1 | Positive-going horizontal sync |
| vSyncOut | output | 1 | Selected positive-going vertical sync |
| status | output | 5 | {compPolNeg, vertPolNeg, extrPresent, compPresent, vertPresent} |

## Verification
The hardest state to reach is a composite input whose serrated vertical interval briefly reverses the high/low ratio. The polarity decision must ride through those lines, while the extractor has to fire on the same lines and stay silent on plain line pulses. The bench drives a framed waveform, in both polarities, of sixteen 64-cycle lines with a three-line serrated interval. It runs several frames to settle, then samples the outputs at fixed line and cycle positions inside and outside the interval. The vertical input is placed in a different set of lines from the composite interval, so each sample shows which source the selector chose.

// File: rtl/sync_fe_pkg.sv
package sync_fe_pkg;

  // Events reported by the datapath to the control
  typedef struct packed {
    logic compLevel;
    logic vertLevel;
    logic compEdge;
    logic vertEdge;
    logic extrEdge;
  } dpEvents_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic invComp;
    logic invVert;
    logic useExtract;
  } ctlStrobes_t;

  localparam int STAT_VERT_PRES = 0;
  localparam int STAT_COMP_PRES = 1;
  localparam int STAT_EXTR_PRES = 2;
  localparam int STAT_VERT_NEG  = 3;
  localparam int STAT_COMP_NEG  = 4;
  localparam int STAT_W         = 5;

endpackage

// File: rtl/sync_fe_polarity_meter.sv
module sync_fe_polarity_meter #(
  parameter int PER_W       = 16,
  parameter int POL_CONFIRM = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic level,
  input  logic edgeSeen,
  output logic polNeg
);
  localparam int AW = $clog2(POL_CONFIRM + 1);
  localparam logic [PER_W-1:0] RUN_MAX = '1;

  logic [PER_W-1:0] hiRun, loRun, lastHi;
  logic [AW-1:0]    agreeCnt;
  logic             seenFall;
  logic             riseNow, fallNow, candNeg;

  assign riseNow = edgeSeen && level;
  assign fallNow = edgeSeen && !level;
  // low run just ended versus the high run before it; tie -> positive
  assign candNeg = loRun < lastHi;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiRun    <= '0;
      loRun    <= '0;
      lastHi   <= '0;
      agreeCnt <= '0;
      seenFall <= 1'b0;
      polNeg   <= 1'b0;
    end else if (riseNow) begin
      loRun <= '0;
      hiRun <= PER_W'(1);
      if (seenFall) begin
        if (candNeg != polNeg) begin
          if (agreeCnt == AW'(POL_CONFIRM - 1)) begin
            polNeg   <= candNeg;
            agreeCnt <= '0;
          end else begin
            agreeCnt <= agreeCnt + AW'(1);
          end
        end else begin
          agreeCnt <= '0;
        end
      end
    end else if (fallNow) begin
      lastHi   <= hiRun;
      hiRun    <= '0;
      loRun    <= PER_W'(1);
      seenFall <= 1'b1;
    end else if (level) begin
      if (hiRun != RUN_MAX) hiRun <= hiRun + PER_W'(1);
    end else begin
      if (loRun != RUN_MAX) loRun <= loRun + PER_W'(1);
    end
  end

  // R3: the decision may only move on a rising edge of the input
  assert_pol_change_at_rise_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(polNeg) |-> $past(riseNow));

endmodule

// File: rtl/sync_fe_presence_timer.sv
module sync_fe_presence_timer #(
  parameter int PRES_TIMEOUT = 65536
) (
  input  logic clk,
  input  logic rstN,
  input  logic edgeSeen,
  output logic present
);
  localparam int CW = $clog2(PRES_TIMEOUT + 1);

  logic [CW-1:0] quietCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quietCnt <= '0;
      present  <= 1'b0;
    end else if (edgeSeen) begin
      quietCnt <= '0;
      present  <= 1'b1;
    end else if (present) begin
      if (quietCnt == CW'(PRES_TIMEOUT - 1)) present <= 1'b0;
      quietCnt <= quietCnt + CW'(1);
    end
  end

  // R6: an edge always leaves the flag set
  assert_present_on_edge_R6: assert property (@(posedge clk) disable iff (!rstN)
    edgeSeen |=> present);

  // R6: an absent flag stays absent until an edge arrives
  assert_absent_holds_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!present && !edgeSeen) |=> !present);

endmodule

// File: rtl/sync_fe_datapath.sv
module sync_fe_datapath import sync_fe_pkg::*; #(
  parameter int SYNC_STAGES  = 2,
  parameter int INTEG_W      = 8,
  parameter int INTEG_THRESH = 100
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        compSyncIn,
  input  logic        vertSyncIn,
  input  ctlStrobes_t ctl,
  output dpEvents_t   evt,
  output logic        hSyncOut,
  output logic        vSyncOut
);
  localparam logic [INTEG_W-1:0] INTEG_MAX = '1;
  localparam logic [INTEG_W-1:0] INTEG_TH  = INTEG_W'(INTEG_THRESH);

  logic [1:0] rawIn, syncd, prevSyncd;
  logic       compCorr, vertCorr;
  logic [INTEG_W-1:0] integCnt;
  logic       extrActive, extrPrev;
  logic       hSyncReg, vSyncReg;

  assign rawIn = {vertSyncIn, compSyncIn};

  // one synchronizer chain per input
  for (genvar ch = 0; ch < 2; ch++) begin : g_sync
    logic [SYNC_STAGES-1:0] shReg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        shReg        <= '0;
        prevSyncd[ch] <= 1'b0;
      end else begin
        shReg        <= {shReg[SYNC_STAGES-2:0], rawIn[ch]};
        prevSyncd[ch] <= shReg[SYNC_STAGES-1];
      end
    end
    assign syncd[ch] = shReg[SYNC_STAGES-1];
  end

  assign compCorr = syncd[0] ^ ctl.invComp;
  assign vertCorr = syncd[1] ^ ctl.invVert;

  // integrating extractor
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      integCnt <= '0;
    end else if (compCorr) begin
      if (integCnt != INTEG_MAX) integCnt <= integCnt + INTEG_W'(1);
    end else begin
      if (integCnt != '0) integCnt <= integCnt - INTEG_W'(1);
    end
  end

  assign extrActive = integCnt > INTEG_TH;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extrPrev <= 1'b0;
      hSyncReg <= 1'b0;
      vSyncReg <= 1'b0;
    end else begin
      extrPrev <= extrActive;
      hSyncReg <= compCorr;
      vSyncReg <= ctl.useExtract ? extrActive : vertCorr;
    end
  end

  assign hSyncOut = hSyncReg;
  assign vSyncOut = vSyncReg;

  assign evt.compLevel = syncd[0];
  assign evt.vertLevel = syncd[1];
  assign evt.compEdge  = syncd[0] ^ prevSyncd[0];
  assign evt.vertEdge  = syncd[1] ^ prevSyncd[1];
  assign evt.extrEdge  = extrActive ^ extrPrev;

  // R5: the extracted vertical can only start while the corrected composite is active
  assert_extract_rises_active_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(extrActive) |-> $past(compCorr));

endmodule

// File: rtl/sync_fe_control.sv
module sync_fe_control import sync_fe_pkg::*; #(
  parameter int PER_W        = 16,
  parameter int POL_CONFIRM  = 8,
  parameter int PRES_TIMEOUT = 65536
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpEvents_t         evt,
  input  logic              cfgAutoPol,
  input  logic              cfgCompInv,
  input  logic              cfgVertInv,
  input  logic              cfgAutoSel,
  input  logic              cfgSelExtract,
  output ctlStrobes_t       ctl,
  output logic [STAT_W-1:0] status
);
  localparam int N_PRES = 3;

  logic [1:0]        lvl, edg, polNeg;
  logic [N_PRES-1:0] presEdge, presFlag;

  assign lvl = {evt.vertLevel, evt.compLevel};
  assign edg = {evt.vertEdge,  evt.compEdge};

  // index 0: composite, index 1: vertical
  for (genvar p = 0; p < 2; p++) begin : g_pol
    sync_fe_polarity_meter #(.PER_W(PER_W), .POL_CONFIRM(POL_CONFIRM)) pol_i (
      .clk(clk), .rstN(rstN), .level(lvl[p]), .edgeSeen(edg[p]), .polNeg(polNeg[p]));
  end

  // index 0: vertical, 1: composite, 2: extracted
  assign presEdge = {evt.extrEdge, evt.compEdge, evt.vertEdge};
  for (genvar q = 0; q < N_PRES; q++) begin : g_pres
    sync_fe_presence_timer #(.PRES_TIMEOUT(PRES_TIMEOUT)) pres_i (
      .clk(clk), .rstN(rstN), .edgeSeen(presEdge[q]), .present(presFlag[q]));
  end

  assign ctl.invComp    = cfgAutoPol ? polNeg[0] : cfgCompInv;
  assign ctl.invVert    = cfgAutoPol ? polNeg[1] : cfgVertInv;
  assign ctl.useExtract = cfgAutoSel ? !presFlag[0] : cfgSelExtract;

  always_comb begin
    status                 = '0;
    status[STAT_VERT_PRES] = presFlag[0];
    status[STAT_COMP_PRES] = presFlag[1];
    status[STAT_EXTR_PRES] = presFlag[2];
    status[STAT_VERT_NEG]  = polNeg[1];
    status[STAT_COMP_NEG]  = polNeg[0];
  end

endmodule

// File: rtl/sync_frontend.sv
module sync_frontend #(
  parameter int SYNC_STAGES  = 2,
  parameter int PER_W        = 16,
  parameter int POL_CONFIRM  = 8,
  parameter int INTEG_W      = 8,
  parameter int INTEG_THRESH = 100,
  parameter int PRES_TIMEOUT = 65536
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       compSyncIn,
  input  logic       vertSyncIn,
  input  logic       cfgAutoPol,
  input  logic       cfgCompInv,
  input  logic       cfgVertInv,
  input  logic       cfgAutoSel,
  input  logic       cfgSelExtract,
  output logic       hSyncOut,
  output logic       vSyncOut,
  output logic [4:0] status
);
  import sync_fe_pkg::*;

  dpEvents_t   evt;
  ctlStrobes_t ctl;

  sync_fe_datapath #(
    .SYNC_STAGES(SYNC_STAGES), .INTEG_W(INTEG_W), .INTEG_THRESH(INTEG_THRESH)
  ) datapath_i (
    .clk(clk), .rstN(rstN), .compSyncIn(compSyncIn), .vertSyncIn(vertSyncIn),
    .ctl(ctl), .evt(evt), .hSyncOut(hSyncOut), .vSyncOut(vSyncOut));

  sync_fe_control #(
    .PER_W(PER_W), .POL_CONFIRM(POL_CONFIRM), .PRES_TIMEOUT(PRES_TIMEOUT)
  ) control_i (
    .clk(clk), .rstN(rstN), .evt(evt), .cfgAutoPol(cfgAutoPol),
    .cfgCompInv(cfgCompInv), .cfgVertInv(cfgVertInv), .cfgAutoSel(cfgAutoSel),
    .cfgSelExtract(cfgSelExtract), .ctl(ctl), .status(status));

endmodule

// File: tb/sync_frontend_tb_top.sv
`timescale 1ns/1ps
module sync_frontend_tb_top;
  localparam int LINE   = 64;   // cycles per line
  localparam int FRAME  = 16;   // lines per frame
  localparam int HW     = 8;    // horizontal pulse width
  localparam int VL     = 3;    // vertical interval lines
  localparam int SERR   = 8;    // serration gap in vertical lines
  localparam int VSTART = 8;    // first line of the dedicated vertical pulse
  localparam int SETTLE = 8 * LINE * FRAME;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic compSyncIn = 1'b0, vertSyncIn = 1'b0;
  logic cfgAutoPol = 1'b1, cfgCompInv = 1'b0, cfgVertInv = 1'b0;
  logic cfgAutoSel = 1'b1, cfgSelExtract = 1'b0;
  logic hSyncOut, vSyncOut;
  logic [4:0] status;

  int nChecks = 0, nFails = 0;
  int cycCnt = 0, lineCnt = 0;
  int compMode = 0;             // 0 idle, 1 horizontal only, 2 composite
  logic compNeg = 1'b0, vertOn = 1'b0, vertNeg = 1'b0;

  always #10 clk = ~clk;

  sync_frontend #(
    .SYNC_STAGES(2), .PER_W(16), .POL_CONFIRM(6), .INTEG_W(6),
    .INTEG_THRESH(24), .PRES_TIMEOUT(2048)
  ) dut_i (.*);

  // stimulus generator: framed sync waveforms
  always @(negedge clk) begin
    logic ca, va;
    if (cycCnt == LINE - 1) begin
      cycCnt = 0;
      lineCnt = (lineCnt == FRAME - 1) ? 0 : lineCnt + 1;
    end else begin
      cycCnt = cycCnt + 1;
    end
    case (compMode)
      1:       ca = (cycCnt < HW);
      2:       ca = (lineCnt < VL) ? (cycCnt < LINE - SERR) : (cycCnt < HW);
      default: ca = 1'b0;
    endcase
    va = vertOn && (lineCnt >= VSTART) && (lineCnt < VSTART + VL);
    compSyncIn = compNeg ^ ca;
    vertSyncIn = vertNeg ^ va;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitAt(input int l, input int c);
    do @(posedge clk); while (!(lineCnt == l && cycCnt == c));
    @(negedge clk);
  endtask

  task automatic settle();
    repeat (SETTLE) @(posedge clk);
  endtask

  task automatic testReset();
    @(negedge clk);
    check(status == 5'd0, "R9 status", status, 0);
    check(hSyncOut == 1'b0 && vSyncOut == 1'b0, "R9 outputs", {hSyncOut, vSyncOut}, 0);
  endtask

  task automatic testHorizPositive();
    logic anyV;
    compMode = 1; compNeg = 0;
    settle();
    @(negedge clk);
    check(status[1] == 1'b1, "R6 composite present", status[1], 1);
    check(status[4] == 1'b0, "R2 composite polarity positive", status[4], 0);
    waitAt(5, 6);
    check(hSyncOut == 1'b1, "R1 hsync in pulse", hSyncOut, 1);
    waitAt(5, 40);
    check(hSyncOut == 1'b0, "R1 hsync between pulses", hSyncOut, 0);
    anyV = 1'b0;
    repeat (LINE * FRAME) begin
      @(negedge clk);
      anyV = anyV | vSyncOut;
    end
    check(anyV == 1'b0, "R5 no extraction from line pulses", anyV, 0);
    check(status[2] == 1'b0, "R5 extracted absent", status[2], 0);
  endtask

  task automatic testHorizNegative();
    compMode = 1; compNeg = 1;
    settle();
    @(negedge clk);
    check(status[4] == 1'b1, "R2 composite polarity negative", status[4], 1);
    waitAt(5, 6);
    check(hSyncOut == 1'b1, "R4 auto inversion in pulse", hSyncOut, 1);
    waitAt(5, 40);
    check(hSyncOut == 1'b0, "R4 auto inversion between", hSyncOut, 0);
  endtask

  task automatic testManualInvert();
    compMode = 1; compNeg = 0;
    cfgAutoPol = 0; cfgCompInv = 1;
    settle();
    waitAt(5, 6);
    check(hSyncOut == 1'b0, "R4 manual inversion in pulse", hSyncOut, 0);
    waitAt(5, 40);
    check(hSyncOut == 1'b1, "R4 manual inversion between", hSyncOut, 1);
    cfgAutoPol = 1; cfgCompInv = 0;
  endtask

  task automatic testComposite(input logic neg);
    compMode = 2; compNeg = neg; vertOn = 0;
    settle();
    waitAt(2, 32);
    check(vSyncOut == 1'b1, "R5 extracted high in interval", vSyncOut, 1);
    check(status[4] == neg, "R3 polarity held through serration", status[4], neg);
    waitAt(4, 5);
    check(status[4] == neg, "R3 polarity held after interval", status[4], neg);
    check(hSyncOut == 1'b1, "R1 composite line pulse", hSyncOut, 1);
    waitAt(8, 32);
    check(vSyncOut == 1'b0, "R5 extracted low outside interval", vSyncOut, 0);
    check(status[2] == 1'b1, "R6 extracted present", status[2], 1);
    check(status[0] == 1'b0, "R6 vertical absent", status[0], 0);
  endtask

  task automatic testAutoSelVert();
    compMode = 2; compNeg = 0; vertOn = 1; vertNeg = 1;
    settle();
    @(negedge clk);
    check(status == 5'b01111, "R6 R2 full status", status, 5'b01111);
    waitAt(9, 32);
    check(vSyncOut == 1'b1, "R7 auto picks vertical input", vSyncOut, 1);
    waitAt(2, 32);
    check(vSyncOut == 1'b0, "R7 extracted not used", vSyncOut, 0);
  endtask

  task automatic testManualSel();
    cfgAutoSel = 0; cfgSelExtract = 1;
    waitAt(FRAME - 1, 0);
    waitAt(2, 32);
    check(vSyncOut == 1'b1, "R8 manual extracted in interval", vSyncOut, 1);
    waitAt(9, 32);
    check(vSyncOut == 1'b0, "R8 manual extracted ignores vertical", vSyncOut, 0);
    cfgSelExtract = 0;
    waitAt(FRAME - 1, 0);
    waitAt(9, 32);
    check(vSyncOut == 1'b1, "R8 manual vertical input", vSyncOut, 1);
    waitAt(2, 32);
    check(vSyncOut == 1'b0, "R8 manual vertical ignores extracted", vSyncOut, 0);
    cfgAutoSel = 1;
  endtask

  task automatic testTimeout();
    compMode = 0; compNeg = 0; vertOn = 0; vertNeg = 0;
    repeat (1000) @(posedge clk);
    @(negedge clk);
    check(status[1] == 1'b1, "R6 composite still present before timeout", status[1], 1);
    repeat (4000) @(posedge clk);
    @(negedge clk);
    check(status[2:0] == 3'b000, "R6 presence timed out", status[2:0], 0);
    check(status[3] == 1'b1, "R2 vertical polarity retained", status[3], 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testHorizPositive();
    testHorizNegative();
    testManualInvert();
    testComposite(1'b0);
    testComposite(1'b1);
    testAutoSelVert();
    testManualSel();
    testTimeout();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule